// File: doc/BRIEF.md
# Machine-mode CSR unit

This block is the machine-level control and status register file of a single-cycle RV32 core. It decodes a 12-bit CSR address. It holds the status, trap-vector, exception-PC and cause registers, plus a free-running 64-bit cycle counter that software reads as two 32-bit halves. For every CSR instruction it returns the old value of the addressed register, for writeback to rd. In the same clock edge it applies the atomic write, set or clear operation, using either the rs1 register value or the 5-bit immediate.

The interrupt controller drives two requests. A trap-entry request saves the faulting PC and the cause and stacks the interrupt enable. A trap-return request unstacks the interrupt enable. The core takes the jump target from `mtvec_o` on a trap and from `mepc_o` on a return. The data width `XLEN` is a parameter: the CSRs are `XLEN` bits wide and the cycle counter is `2*XLEN` bits wide. The default is 32.

Top module: `mcsr_unit`

## Requirements
- R1: While `rst_ni` is low, all CSRs and the cycle counter are zero. This shows on `mstatus_o`, `mtvec_o`, `mepc_o` and on `rdata_o` for every address.
- R2: The addresses decode as follows: status at 0x300, trap vector at 0x305, exception PC at 0x341, cause at 0x342, cycle low half at 0xC00 and cycle high half at 0xC80. Any other address reads zero, and a write to it changes no CSR.
- R3: `csr_op_i` takes the funct3 encoding: 001 write, 010 set, 011 clear, 101 write-immediate, 110 set-immediate, 111 clear-immediate. The codes 000 and 100 write nothing. For codes whose bit 2 is 1, the operand is `rs1_idx_i` zero-extended and `rs1_data_i` is ignored. Otherwise the operand is `rs1_data_i`.
- R4: The write forms return the old value on `rdata_o` and replace the CSR with the operand. They write even when the operand field is zero.
- R5: The set forms return the old value and store old OR operand. When `rs1_idx_i` is 0 they write nothing, whatever `rs1_data_i` holds.
- R6: The clear forms return the old value and store old AND NOT operand. When `rs1_idx_i` is 0 they write nothing.
- R7: Only bit 3 (MIE) and bit 7 (MPIE) of the status register are implemented. All its other bits read zero and ignore writes.
- R8: Bits [1:0] of the trap vector read zero (direct mode only). The exception PC and cause registers are fully writable.
- R9: When `trap_i` is high at a clock edge, the exception PC takes `trap_pc_i` and the cause takes `trap_cause_i`. MPIE takes the old MIE and MIE clears. A trap takes precedence over a CSR write and over `mret_i` in the same cycle.
- R10: When `mret_i` is high (and `trap_i` is low) at a clock edge, MIE takes the old MPIE and MPIE sets to 1. This takes precedence over a CSR write to the status register in the same cycle.
- R11: The cycle counter increments by one at every clock edge out of reset and wraps at 2^(2*XLEN). Writes to its two addresses are ignored.
- R12: `rdata_o` always shows the addressed CSR's current value, whether `csr_en_i` is high or low. With `csr_en_i` low, nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_en_i | input | 1 | A CSR instruction executes this cycle |
| csr_op_i | input | 3 | funct3 of the CSR instruction |
| csr_addr_i | input | 12 | CSR address |
| rs1_idx_i | input | 5 | rs1 field; the immediate in the immediate forms |
| rs1_data_i | input | XLEN | Value of register rs1 |
| rdata_o | output | XLEN | Old value of the addressed CSR |
| trap_i | input | 1 | Trap-entry request |
| trap_pc_i | input | XLEN | PC of the trapping instruction |
| trap_cause_i | input | XLEN | Trap cause code |
| mret_i | input | 1 | Trap-return request |
| mstatus_o | output | XLEN | Status register |
| mtvec_o | output | XLEN | Trap handler base address |
| mepc_o | output | XLEN | Saved exception PC |

## Verification
The bench runs an 8-bit instance and sweeps every operand value through all six operations on the cause register, starting from several old values. The set and clear forms are also driven with rs1 index 0 and a non-zero data value. A design that ignored the index would corrupt the register, and one that used `rs1_data_i` in the immediate forms would store 0xFF patterns. The bench walks trap entry and return over every MIE/MPIE pair and collides each with a CSR write or with the other request. A wrong priority order would leave a stray status or exception-PC value. The 16-bit counter is compared every cycle across its wrap, which catches a missing carry into the high half and a counter that a write can reload.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam logic [11:0] ADDR_MSTATUS = 12'h300;
  localparam logic [11:0] ADDR_MTVEC   = 12'h305;
  localparam logic [11:0] ADDR_MEPC    = 12'h341;
  localparam logic [11:0] ADDR_MCAUSE  = 12'h342;
  localparam logic [11:0] ADDR_CYC_LO  = 12'hC00;
  localparam logic [11:0] ADDR_CYC_HI  = 12'hC80;

  localparam int MIE_BIT  = 3;
  localparam int MPIE_BIT = 7;
  localparam int IMM_W    = 5;

  typedef enum logic [1:0] {
    RMW_NONE  = 2'b00,
    RMW_WRITE = 2'b01,
    RMW_SET   = 2'b10,
    RMW_CLEAR = 2'b11
  } rmw_kind_e;

  typedef struct packed {
    logic mstatus;
    logic mtvec;
    logic mepc;
    logic mcause;
    logic cyc_lo;
    logic cyc_hi;
  } csr_sel_t;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
  import mcsr_pkg::*;
(
  input  logic [11:0] addr_i,
  output csr_sel_t    sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (addr_i)
      ADDR_MSTATUS: sel_o.mstatus = 1'b1;
      ADDR_MTVEC:   sel_o.mtvec   = 1'b1;
      ADDR_MEPC:    sel_o.mepc    = 1'b1;
      ADDR_MCAUSE:  sel_o.mcause  = 1'b1;
      ADDR_CYC_LO:  sel_o.cyc_lo  = 1'b1;
      ADDR_CYC_HI:  sel_o.cyc_hi  = 1'b1;
      default:      sel_o = '0;
    endcase
  end
endmodule

// File: rtl/csr_rmw.sv
module csr_rmw
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]       op_i,
  input  logic [4:0]       rs1_idx_i,
  input  logic [XLEN-1:0]  rs1_data_i,
  input  logic [XLEN-1:0]  old_i,
  output logic [XLEN-1:0]  new_o,
  output logic             wr_o
);
  logic [XLEN-1:0] operand;
  logic            src_zero;
  rmw_kind_e       kind;

  assign operand  = op_i[2] ? {{(XLEN-IMM_W){1'b0}}, rs1_idx_i} : rs1_data_i;
  // set/clear suppress the write on a zero source field, not a zero value
  assign src_zero = (rs1_idx_i == '0);
  assign kind     = rmw_kind_e'(op_i[1:0]);

  always_comb begin
    new_o = old_i;
    wr_o  = 1'b0;
    unique case (kind)
      RMW_WRITE: begin new_o = operand;          wr_o = 1'b1;      end
      RMW_SET:   begin new_o = old_i | operand;  wr_o = !src_zero; end
      RMW_CLEAR: begin new_o = old_i & ~operand; wr_o = !src_zero; end
      default:   begin new_o = old_i;            wr_o = 1'b0;      end
    endcase
  end
endmodule

// File: rtl/csr_cycle_ctr.sv
module csr_cycle_ctr #(
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R11
  cycle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> cnt_q == CW'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_en_i,
  input  logic [2:0]      csr_op_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [4:0]      rs1_idx_i,
  input  logic [XLEN-1:0] rs1_data_i,
  output logic [XLEN-1:0] rdata_o,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic            mret_i,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] mepc_o
);
  localparam int CW = 2 * XLEN;

  csr_sel_t        sel;
  logic [CW-1:0]   cyc;
  logic [XLEN-1:0] old_val, new_val, mstatus_rd;
  logic            rmw_wr, we, mret_eff;

  logic            mie_q, mpie_q;
  logic [XLEN-3:0] mtvec_q;
  logic [XLEN-1:0] mepc_q, mcause_q;

  csr_addr_dec u_dec (.addr_i(csr_addr_i), .sel_o(sel));

  csr_cycle_ctr #(.CW(CW)) u_cyc (.clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cyc));

  csr_rmw #(.XLEN(XLEN)) u_rmw (
    .op_i(csr_op_i), .rs1_idx_i(rs1_idx_i), .rs1_data_i(rs1_data_i),
    .old_i(old_val), .new_o(new_val), .wr_o(rmw_wr)
  );

  always_comb begin
    mstatus_rd           = '0;
    mstatus_rd[MIE_BIT]  = mie_q;
    mstatus_rd[MPIE_BIT] = mpie_q;
  end

  always_comb begin
    old_val = '0;
    unique case (1'b1)
      sel.mstatus: old_val = mstatus_rd;
      sel.mtvec:   old_val = {mtvec_q, 2'b00};
      sel.mepc:    old_val = mepc_q;
      sel.mcause:  old_val = mcause_q;
      sel.cyc_lo:  old_val = cyc[XLEN-1:0];
      sel.cyc_hi:  old_val = cyc[CW-1:XLEN];
      default:     old_val = '0;
    endcase
  end

  // trap outranks retirement of any instruction in the same cycle
  assign we       = csr_en_i && rmw_wr && !trap_i;
  assign mret_eff = mret_i && !trap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
    end else if (trap_i) begin
      mpie_q <= mie_q;
      mie_q  <= 1'b0;
    end else if (mret_eff) begin
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
    end else if (we && sel.mstatus) begin
      mie_q  <= new_val[MIE_BIT];
      mpie_q <= new_val[MPIE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mtvec_q <= '0;
    else if (we && sel.mtvec)   mtvec_q <= new_val[XLEN-1:2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mepc_q <= '0;
    else if (trap_i)           mepc_q <= trap_pc_i;
    else if (we && sel.mepc)   mepc_q <= new_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mcause_q <= '0;
    else if (trap_i)           mcause_q <= trap_cause_i;
    else if (we && sel.mcause) mcause_q <= new_val;
  end

  assign rdata_o   = old_val;
  assign mstatus_o = mstatus_rd;
  assign mtvec_o   = {mtvec_q, 2'b00};
  assign mepc_o    = mepc_q;

  // R9
  trap_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (mepc_q == $past(trap_pc_i)) && (mcause_q == $past(trap_cause_i)));

  // R9
  trap_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !mie_q && (mpie_q == $past(mie_q)));

  // R10
  mret_unstack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_i) |=> mpie_q && (mie_q == $past(mpie_q)));

  // R5 R6
  zero_src_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && csr_op_i[1] && (rs1_idx_i == 5'd0) && !trap_i) |=> $stable(mcause_q) && $stable(mepc_q));

  // R12
  idle_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_en_i && !trap_i && !mret_i) |=> $stable(mtvec_q) && $stable(mie_q) && $stable(mpie_q));
endmodule

// File: tb/sim_mcsr_unit.sv
`timescale 1ns/1ps
module sim_mcsr_unit;
  localparam int XLEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 1'b0;
  logic [2:0]  csr_op = 3'd0;
  logic [11:0] csr_addr = 12'h000;
  logic [4:0]  rs1_idx = 5'd0;
  logic [7:0]  rs1_data = 8'h00;
  logic [7:0]  rdata;
  logic        trap = 1'b0;
  logic [7:0]  trap_pc = 8'h00;
  logic [7:0]  trap_cause = 8'h00;
  logic        mret = 1'b0;
  logic [7:0]  mstatus, mtvec, mepc;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] cyc_ref;

  always #2 clk = ~clk;

  mcsr_unit #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_en_i(csr_en), .csr_op_i(csr_op),
    .csr_addr_i(csr_addr), .rs1_idx_i(rs1_idx), .rs1_data_i(rs1_data),
    .rdata_o(rdata), .trap_i(trap), .trap_pc_i(trap_pc),
    .trap_cause_i(trap_cause), .mret_i(mret), .mstatus_o(mstatus),
    .mtvec_o(mtvec), .mepc_o(mepc)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc_ref <= 16'd0;
    else        cyc_ref <= cyc_ref + 16'd1;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    csr_en = 1'b0; trap = 1'b0; mret = 1'b0;
  endtask

  // one CSR instruction; old = rdata in that cycle
  task automatic op(input logic [2:0] o, input logic [11:0] a, input logic [4:0] idx,
                    input logic [7:0] d, output logic [7:0] old);
    @(negedge clk);
    csr_en = 1'b1; csr_op = o; csr_addr = a; rs1_idx = idx; rs1_data = d;
    #1 old = rdata;
    @(posedge clk); #1 clr();
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    op(3'b010, a, 5'd0, 8'hFF, v);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    logic [7:0] junk;
    op(3'b001, a, 5'd1, d, junk);
  endtask

  task automatic evt(input logic t, input logic m, input logic [7:0] pc, input logic [7:0] cause,
                     input logic en, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    trap = t; mret = m; trap_pc = pc; trap_cause = cause;
    csr_en = en; csr_op = 3'b001; csr_addr = a; rs1_idx = 5'd1; rs1_data = d;
    @(posedge clk); #1 clr();
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, old, e;
    logic [7:0] pats [4];
    logic [11:0] bad [7];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    bad  = '{12'h000, 12'h301, 12'h340, 12'h343, 12'hC01, 12'hC81, 12'h700};

    // R1 reset state
    #3;
    chk("R1 mstatus", {8'h0, mstatus}, 16'h0);
    chk("R1 mtvec", {8'h0, mtvec}, 16'h0);
    chk("R1 mepc", {8'h0, mepc}, 16'h0);
    foreach (bad[i]) begin end
    csr_addr = 12'h342; #1 chk("R1 mcause", {8'h0, rdata}, 16'h0);
    csr_addr = 12'hC00; #1 chk("R1 cycle lo", {8'h0, rdata}, 16'h0);
    csr_addr = 12'hC80; #1 chk("R1 cycle hi", {8'h0, rdata}, 16'h0);
    #10 rst_n = 1'b1;

    // R4 R5 R6 register forms on mcause, full sweep
    foreach (pats[p]) begin
      for (int k = 1; k <= 3; k++) begin
        for (int x = 0; x < 256; x++) begin
          wr(12'h342, pats[p]);
          op(3'(k), 12'h342, 5'd9, 8'(x), old);
          chk("R4 R5 R6 old value", {8'h0, old}, {8'h0, pats[p]});
          e = (k == 1) ? 8'(x) : (k == 2) ? (pats[p] | 8'(x)) : (pats[p] & ~8'(x));
          rd(12'h342, v);
          chk("R4 R5 R6 new value", {8'h0, v}, {8'h0, e});
        end
      end
    end

    // R3 immediate forms ignore rs1_data
    foreach (pats[p]) begin
      for (int k = 5; k <= 7; k++) begin
        for (int x = 0; x < 32; x++) begin
          wr(12'h342, pats[p]);
          op(3'(k), 12'h342, 5'(x), 8'hFF, old);
          chk("R3 imm old value", {8'h0, old}, {8'h0, pats[p]});
          e = (k == 5) ? 8'(x) : (k == 6) ? (pats[p] | 8'(x)) : (pats[p] & ~8'(x));
          rd(12'h342, v);
          chk("R3 imm new value", {8'h0, v}, {8'h0, e});
        end
      end
    end

    // R5 R6 zero index blocks write; R3 codes 000/100 write nothing
    wr(12'h342, 8'h12);
    op(3'b011, 12'h342, 5'd0, 8'hFF, old); rd(12'h342, v);
    chk("R6 idx0 clear no write", {8'h0, v}, 16'h0012);
    op(3'b000, 12'h342, 5'd3, 8'hFF, old); rd(12'h342, v);
    chk("R3 code 000 no write", {8'h0, v}, 16'h0012);
    op(3'b100, 12'h342, 5'd3, 8'hFF, old); rd(12'h342, v);
    chk("R3 code 100 no write", {8'h0, v}, 16'h0012);

    // R12 read while disabled, no write
    @(negedge clk);
    csr_en = 1'b0; csr_op = 3'b001; csr_addr = 12'h342; rs1_idx = 5'd1; rs1_data = 8'h77;
    #1 chk("R12 rdata while idle", {8'h0, rdata}, 16'h0012);
    @(posedge clk); #1;
    rd(12'h342, v); chk("R12 idle no write", {8'h0, v}, 16'h0012);

    // R7 R8 implemented bits
    for (int x = 0; x < 256; x++) begin
      wr(12'h300, 8'(x)); rd(12'h300, v);
      chk("R7 mstatus read", {8'h0, v}, {8'h0, 8'(x) & 8'h88});
      chk("R7 mstatus_o", {8'h0, mstatus}, {8'h0, 8'(x) & 8'h88});
      wr(12'h305, 8'(x)); rd(12'h305, v);
      chk("R8 mtvec read", {8'h0, v}, {8'h0, 8'(x) & 8'hFC});
      chk("R8 mtvec_o", {8'h0, mtvec}, {8'h0, 8'(x) & 8'hFC});
      wr(12'h341, 8'(x)); rd(12'h341, v);
      chk("R8 mepc read", {8'h0, v}, {8'h0, 8'(x)});
      chk("R8 mepc_o", {8'h0, mepc}, {8'h0, 8'(x)});
    end

    // R2 unimplemented addresses
    wr(12'h300, 8'h88); wr(12'h305, 8'h40); wr(12'h341, 8'h21); wr(12'h342, 8'h5A);
    foreach (bad[i]) begin
      wr(bad[i], 8'hFF); rd(bad[i], v);
      chk("R2 unimplemented reads zero", {8'h0, v}, 16'h0);
    end
    rd(12'h300, v); chk("R2 mstatus untouched", {8'h0, v}, 16'h0088);
    rd(12'h305, v); chk("R2 mtvec untouched", {8'h0, v}, 16'h0040);
    rd(12'h341, v); chk("R2 mepc untouched", {8'h0, v}, 16'h0021);
    rd(12'h342, v); chk("R2 mcause untouched", {8'h0, v}, 16'h005A);

    // R9 R10 all MIE/MPIE pairs
    for (int s = 0; s < 4; s++) begin
      e = (s[0] ? 8'h08 : 8'h00) | (s[1] ? 8'h80 : 8'h00);
      wr(12'h300, e);
      evt(1'b1, 1'b0, 8'(8'h40 + s), 8'(s + 1), 1'b0, 12'h000, 8'h00);
      chk("R9 trap stack", {8'h0, mstatus}, {8'h0, s[0] ? 8'h80 : 8'h00});
      chk("R9 trap mepc", {8'h0, mepc}, {8'h0, 8'(8'h40 + s)});
      rd(12'h342, v); chk("R9 trap mcause", {8'h0, v}, {8'h0, 8'(s + 1)});
      wr(12'h300, e);
      evt(1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 12'h000, 8'h00);
      chk("R10 mret unstack", {8'h0, mstatus}, {8'h0, 8'h80 | (s[1] ? 8'h08 : 8'h00)});
    end

    // R9 priority over CSR write and mret
    wr(12'h300, 8'h08);
    evt(1'b1, 1'b0, 8'h44, 8'h0B, 1'b1, 12'h341, 8'h99);
    chk("R9 trap beats mepc write", {8'h0, mepc}, 16'h0044);
    wr(12'h300, 8'h08);
    evt(1'b1, 1'b1, 8'h48, 8'h03, 1'b1, 12'h342, 8'hEE);
    chk("R9 trap beats mret", {8'h0, mstatus}, 16'h0080);
    rd(12'h342, v); chk("R9 trap beats mcause write", {8'h0, v}, 16'h0003);
    // R10 mret beats status write
    wr(12'h300, 8'h80);
    evt(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 12'h300, 8'h00);
    chk("R10 mret beats mstatus write", {8'h0, mstatus}, 16'h0088);

    // R11 writes to counter ignored, then run across the 16-bit wrap
    wr(12'hC00, 8'h00); wr(12'hC80, 8'h00);
    for (int n = 0; n < 67000; n++) begin
      @(negedge clk);
      csr_addr = n[0] ? 12'hC80 : 12'hC00;
      #1 chk("R11 cycle counter", {8'h0, rdata}, {8'h0, n[0] ? cyc_ref[15:8] : cyc_ref[7:0]});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule